// File: doc/BRIEF.md
# Condition-Flag ALU with Branch Resolver

This block is the arithmetic and condition unit of a small byte-coded processor. It takes two 16-bit data words and a 3-bit operation code and computes one of six operations: add, subtract, AND, OR, XOR and move. It writes the result, and the four condition flags that describe it, to registers on the same clock edge. The flags sit in the low nibble of an 8-bit processor state word. The high nibble of that word holds the operand-section pair most recently selected by the decoder.

The same block also handles flag commands. A flag command is a byte whose high nibble picks one flag: `A` picks negative, `B` picks overflow, `C` picks carry and `D` picks differs. Without a pointer prefix, a command with low nibble `F` inverts the chosen flag. With a pointer prefix, the command becomes a conditional jump. Low nibble `F` jumps when the flag is clear, and low nibble `E` jumps when the flag is set. The byte `F8` is an interrupt call.

Every jump and every interrupt asks the decoder to store the current instruction pointer in the link register. A jump or interrupt also produces the next instruction-pointer value. Instruction decoding and the register file are outside this block.

Top module: `flag_alu`

## Requirements
- R1: While reset is asserted, and after it is released, `result` reads 0 and `psw` reads 0x00.
- R2: For op_code 0 (add), one clock edge after `op_valid`, `result` = a+b mod 2^16. psw[1] (carry) is the carry out of bit 15. psw[2] (overflow) is set when both operands have the same sign and the result's sign differs from it.
- R3: For op_code 1 (subtract), one clock edge after `op_valid`, `result` = a−b mod 2^16. psw[1] is set when b > a as unsigned numbers (borrow). psw[2] is set when the operands differ in sign and the result's sign differs from a's sign.
- R4: op_code 2 gives a AND b, op_code 3 gives a OR b, op_code 4 gives a XOR b and op_code 5 passes b through (move). Each is registered on the next edge and clears psw[1] and psw[2].
- R5: For every valid operation, psw[0] (differs) is set exactly when the new result is nonzero, and psw[3] (negative) equals bit 15 of the new result.
- R6: op_codes 6 and 7 change neither `result` nor `psw`.
- R7: When `sect_valid` is high, psw[7:4] loads `sect` on the next edge. Operations and flag commands never change psw[7:4].
- R8: An unprefixed command with low nibble F and high nibble A, B, C or D inverts psw bit 3, 2, 1 or 0 respectively on the next edge. When a valid operation arrives in the same cycle, the inversion applies to the newly computed flag.
- R9: A prefixed command with low nibble F (jump if clear) or E (jump if set) selects a flag with the same nibble map as R8. In the same cycle, `taken` shows whether the condition holds and `next_ip` equals `target` if it holds and `ip` if it does not. The jump leaves `psw` unchanged.
- R10: Every conditional jump, taken or not, raises `link_we` in the same cycle with `link` = `ip`.
- R11: Command byte 0xF8, with or without a prefix, raises `taken` and `link_we`, sets `link` = `ip` and drives `next_ip` = 0xF800.
- R12: With no command, or with a command byte matching none of the forms above, `taken` and `link_we` are 0 and `next_ip` = `ip`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Execute `op_code` this cycle |
| op_code | input | 3 | 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 move |
| opnd_a | input | 16 | Left operand (accumulator) |
| opnd_b | input | 16 | Right operand |
| sect_valid | input | 1 | Load the operand-section pair |
| sect | input | 4 | Operand-section pair code |
| cmd_valid | input | 1 | Flag command present this cycle |
| cmd | input | 8 | Flag command byte |
| prefixed | input | 1 | A pointer prefix accompanies the command |
| target | input | 16 | Jump target address |
| ip | input | 16 | Current instruction pointer |
| result | output | 16 | Registered ALU result |
| psw | output | 8 | State word: [3] negative, [2] overflow, [1] carry, [0] differs, [7:4] section |
| taken | output | 1 | Jump or interrupt redirects the IP |
| link_we | output | 1 | Write `link` into the link register |
| link | output | 16 | Return address to save |
| next_ip | output | 16 | Instruction pointer for the next instruction |

## Verification
`result` and `psw` each pass through one register, so every operation, section load and flag inversion appears one clock edge after it is driven. The bench drives on the falling edge and samples these outputs on the following falling edge. `taken`, `link_we`, `link` and `next_ip` are combinational from the command inputs and the current flags. The bench checks them a short delay after driving, before the next rising edge. Each jump test first sets the flags through an operation or a complement, so that both outcomes of each condition are exercised.

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int W = 16,
  parameter logic [15:0] INT_VEC = 16'hF800
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [2:0]   op_code,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         sect_valid,
  input  logic [3:0]   sect,
  input  logic         cmd_valid,
  input  logic [7:0]   cmd,
  input  logic         prefixed,
  input  logic [W-1:0] target,
  input  logic [W-1:0] ip,
  output logic [W-1:0] result,
  output logic [7:0]   psw,
  output logic         taken,
  output logic         link_we,
  output logic [W-1:0] link,
  output logic [W-1:0] next_ip
);

  localparam int MSB = W - 1;

  logic [W:0]   wide;
  logic [W-1:0] res_n;
  logic         cy_n, ov_n, known;

  always_comb begin
    wide  = '0;
    res_n = result;
    cy_n  = 1'b0;
    ov_n  = 1'b0;
    known = 1'b1;
    case (op_code)
      3'd0: begin
        wide  = {1'b0, opnd_a} + {1'b0, opnd_b};
        res_n = wide[W-1:0];
        cy_n  = wide[W];
        ov_n  = (opnd_a[MSB] == opnd_b[MSB]) && (res_n[MSB] != opnd_a[MSB]);
      end
      3'd1: begin
        wide  = {1'b0, opnd_a} - {1'b0, opnd_b};
        res_n = wide[W-1:0];
        cy_n  = wide[W];
        ov_n  = (opnd_a[MSB] != opnd_b[MSB]) && (res_n[MSB] != opnd_a[MSB]);
      end
      3'd2: res_n = opnd_a & opnd_b;
      3'd3: res_n = opnd_a | opnd_b;
      3'd4: res_n = opnd_a ^ opnd_b;
      3'd5: res_n = opnd_b;
      default: known = 1'b0;
    endcase
  end

  logic [3:0] mask;
  always_comb begin
    case (cmd[7:4])
      4'hA:    mask = 4'b1000;
      4'hB:    mask = 4'b0100;
      4'hC:    mask = 4'b0010;
      4'hD:    mask = 4'b0001;
      default: mask = 4'b0000;
    endcase
  end

  wire flag_cmd = cmd_valid && (mask != 4'b0000);
  wire lo_f     = cmd[3:0] == 4'hF;
  wire lo_e     = cmd[3:0] == 4'hE;
  wire compl    = flag_cmd && !prefixed && lo_f;
  wire jump     = flag_cmd && prefixed && (lo_f || lo_e);
  wire intr     = cmd_valid && (cmd == 8'hF8);
  wire flag_val = |(psw[3:0] & mask);
  wire cond     = lo_e ? flag_val : !flag_val;
  wire alu_go   = op_valid && known;

  wire [3:0] low_alu = alu_go ? {res_n[MSB], ov_n, cy_n, |res_n} : psw[3:0];
  wire [3:0] low_n   = compl ? (low_alu ^ mask) : low_alu;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      psw    <= '0;
    end else begin
      if (alu_go) result <= res_n;
      psw <= {sect_valid ? sect : psw[7:4], low_n};
    end
  end

  assign taken   = intr || (jump && cond);
  assign link_we = intr || jump;
  assign link    = ip;
  assign next_ip = intr ? INT_VEC[W-1:0] : ((jump && cond) ? target : ip);

endmodule

module flag_alu_chk #(parameter int W = 16) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic [2:0]   op_code,
  input logic         sect_valid,
  input logic         cmd_valid,
  input logic [7:0]   cmd,
  input logic         prefixed,
  input logic [W-1:0] ip,
  input logic [W-1:0] result,
  input logic [7:0]   psw,
  input logic         taken,
  input logic         link_we,
  input logic [W-1:0] link,
  input logic [W-1:0] next_ip
);
  // R6
  unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code[2:1] == 2'b11 && !cmd_valid && !sect_valid) |=> ($stable(result) && $stable(psw)));
  // R8
  carry_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !prefixed && cmd == 8'hCF && !op_valid) |=> (psw[1] != $past(psw[1])));
  // R10
  link_on_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> (link_we && link == ip));
  // R11
  int_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == 8'hF8) |-> (next_ip == 16'hF800 && taken));
  // R12
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> (next_ip == ip && !link_we && !taken));
  // R7
  section_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sect_valid |=> $stable(psw[7:4]));
endmodule

bind flag_alu flag_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .sect_valid(sect_valid), .cmd_valid(cmd_valid), .cmd(cmd), .prefixed(prefixed),
  .ip(ip), .result(result), .psw(psw), .taken(taken), .link_we(link_we),
  .link(link), .next_ip(next_ip)
);

// File: tb/test_flag_alu.sv
module test_flag_alu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [15:0] opnd_a = '0, opnd_b = '0;
  logic        sect_valid = 1'b0;
  logic [3:0]  sect = '0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd = '0;
  logic        prefixed = 1'b0;
  logic [15:0] target = '0, ip = '0;
  logic [15:0] result, link, next_ip;
  logic [7:0]  psw;
  logic        taken, link_we;

  int checks = 0;
  int fails = 0;

  flag_alu i_flag_alu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .sect_valid(sect_valid), .sect(sect),
    .cmd_valid(cmd_valid), .cmd(cmd), .prefixed(prefixed), .target(target),
    .ip(ip), .result(result), .psw(psw), .taken(taken), .link_we(link_we),
    .link(link), .next_ip(next_ip)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    op_valid = 0; sect_valid = 0; cmd_valid = 0; prefixed = 0;
  endtask

  task automatic run_op(input logic [2:0] code, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    op_valid = 1; op_code = code; opnd_a = a; opnd_b = b;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic alu_case(input string req, input logic [2:0] code, input logic [15:0] a,
                          input logic [15:0] b, input logic [15:0] exp_r, input logic [3:0] exp_f);
    run_op(code, a, b);
    check({req, " result"}, result, exp_r);
    check({req, " flags"}, psw[3:0], exp_f);
  endtask

  task automatic test_reset();
    check("R1 result", result, 0);
    check("R1 psw", psw, 0);
  endtask

  task automatic test_add();
    alu_case("R2 add ovf", 0, 16'h7FFF, 16'h0001, 16'h8000, 4'hD);
    alu_case("R2 add carry zero", 0, 16'hFFFF, 16'h0001, 16'h0000, 4'h2);
    alu_case("R2 add plain", 0, 16'h0102, 16'h0304, 16'h0406, 4'h1);
  endtask

  task automatic test_sub();
    alu_case("R3 sub borrow", 1, 16'h0003, 16'h0005, 16'hFFFE, 4'hB);
    alu_case("R3 sub ovf", 1, 16'h8000, 16'h0001, 16'h7FFF, 4'h5);
    alu_case("R3 R5 sub zero", 1, 16'h0005, 16'h0005, 16'h0000, 4'h0);
  endtask

  task automatic test_logic();
    alu_case("R2 setup", 0, 16'h7FFF, 16'h0001, 16'h8000, 4'hD);
    alu_case("R4 and clears cb", 2, 16'hF0F0, 16'h8F00, 16'h8000, 4'h9);
    alu_case("R4 R5 or zero", 3, 16'h0000, 16'h0000, 16'h0000, 4'h0);
    alu_case("R4 xor", 4, 16'h00FF, 16'h0F0F, 16'h0FF0, 4'h1);
    alu_case("R4 R5 move", 5, 16'h1234, 16'h8001, 16'h8001, 4'h9);
  endtask

  task automatic test_unknown();
    run_op(3'd6, 16'h1111, 16'h2222);
    check("R6 op6 result", result, 16'h8001);
    check("R6 op6 psw", psw[3:0], 4'h9);
    run_op(3'd7, 16'hFFFF, 16'h0001);
    check("R6 op7 result", result, 16'h8001);
  endtask

  task automatic test_section();
    @(negedge clk);
    sect_valid = 1; sect = 4'h6;
    @(negedge clk);
    idle_inputs();
    check("R7 section loaded", psw, 8'h69);
    alu_case("R7 op keeps section", 1, 16'h0003, 16'h0005, 16'hFFFE, 4'hB);
    check("R7 high nibble", psw[7:4], 4'h6);
  endtask

  task automatic complement(input logic [7:0] c);
    @(negedge clk);
    cmd_valid = 1; cmd = c; prefixed = 0;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic test_complement();
    complement(8'hAF); check("R8 AF", psw, 8'h63);
    complement(8'hBF); check("R8 BF", psw, 8'h67);
    complement(8'hCF); check("R8 CF", psw, 8'h65);
    complement(8'hDF); check("R8 DF", psw, 8'h64);
    @(negedge clk);
    op_valid = 1; op_code = 0; opnd_a = 16'h0001; opnd_b = 16'h0001;
    cmd_valid = 1; cmd = 8'hCF;
    @(negedge clk);
    idle_inputs();
    check("R8 same-cycle op", psw, 8'h63);
  endtask

  task automatic branch(input string req, input logic [7:0] c, input logic pre,
                        input logic exp_t, input logic exp_we, input logic [15:0] exp_ip);
    @(negedge clk);
    cmd_valid = 1; cmd = c; prefixed = pre; ip = 16'h1234; target = 16'h4567;
    #1;
    check({req, " taken"}, taken, exp_t);
    check({req, " link_we"}, link_we, exp_we);
    if (exp_we) check({req, " link"}, link, 16'h1234);
    check({req, " next_ip"}, next_ip, exp_ip);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic test_branch();
    // flags now 0011: A=0 B=0 C=1 D=1
    branch("R9 R10 jcf on set C", 8'hCF, 1, 0, 1, 16'h1234);
    branch("R9 R10 jce on set C", 8'hCE, 1, 1, 1, 16'h4567);
    branch("R9 jaf on clear A", 8'hAF, 1, 1, 1, 16'h4567);
    branch("R9 jae on clear A", 8'hAE, 1, 0, 1, 16'h1234);
    branch("R9 jdf on set D", 8'hDF, 1, 0, 1, 16'h1234);
    branch("R9 jbe on clear B", 8'hBE, 1, 0, 1, 16'h1234);
    check("R9 psw unchanged", psw, 8'h63);
    branch("R11 interrupt", 8'hF8, 0, 1, 1, 16'hF800);
    branch("R11 interrupt prefixed", 8'hF8, 1, 1, 1, 16'hF800);
    branch("R12 unprefixed E", 8'hCE, 0, 0, 0, 16'h1234);
    branch("R12 other byte", 8'h3D, 1, 0, 0, 16'h1234);
    @(negedge clk);
    ip = 16'h0042; #1;
    check("R12 idle next_ip", next_ip, 16'h0042);
    check("R12 idle link_we", link_we, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    test_reset();
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_add();
    test_sub();
    test_logic();
    test_unknown();
    test_section();
    test_complement();
    test_branch();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule